// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block keeps a 16-bit time base for a small processor subsystem. A bus clock passes through a power-of-two prescaler, and each prescaled tick advances a free-running up-counter. Software cannot load the counter. It can only read it through an 8-bit register port. The full count is also driven out on a wide output, so compare or capture logic elsewhere can watch it.

Software reads the count as a high byte followed by a low byte. The high-byte read freezes the low byte in a holding register, so the two bytes always belong to the same instant even though the counter keeps moving between the accesses. A wrap of the counter sets an overflow flag. The flag raises an interrupt request when its enable bit is set.

The prescale rate is protected against later corruption. Software may choose it once, and only during a short window after reset. Two small state machines carry the behaviour:

- The rate-lock machine has the states LK_OPEN and LK_SHUT. It leaves LK_OPEN either on the first control write (transition `first_write`) or when the window counter expires (transition `window_expired`). LK_SHUT is final until reset.
- The read-hold machine has the states RH_LIVE and RH_HELD. A high-byte read moves RH_LIVE to RH_HELD (transition `capture`). In RH_HELD, a further high-byte read recaptures the low byte (transition `recapture`), and a low-byte read returns to RH_LIVE (transition `release`).

Top module: `frc_timer`

## Requirements
- R1: After reset, `count` is 0x0000, the control register reads 0x00, the status register reads 0x00 and `ovf_irq` is 0.
- R2: The control register (address 2) holds the rate select in bits [1:0]. The values 00, 01, 10 and 11 make the counter advance once every 1, 4 and 8 bus cycles and once every 16 bus cycles, respectively.
- R3: A control write at any of the first 64 rising clock edges after reset release loads the rate select. Only the first such write is accepted.
- R4: Once one control write has been accepted, or once 64 edges have passed, further writes to the rate select are ignored. The interrupt enable, bit 7 of the control register, stays writable at all times.
- R5: Writes to address 0 and address 1 have no effect on the counter.
- R6: A read of address 0 returns count[15:8] and captures count[7:0]. The next read of address 1 returns the captured byte.
- R7: A read of address 1 that has no pending high-byte capture returns the live count[7:0].
- R8: When the counter steps from 0xFFFF to 0x0000, the overflow flag is set. The flag is bit 7 of the status register at address 3.
- R9: `ovf_irq` is 1 exactly when the overflow flag and the interrupt enable are both 1.
- R10: Writing 1 to status bit 7 clears the overflow flag. Writing 0 there leaves the flag unchanged. A wrap in the same cycle as the clear wins.
- R11: The control register reads back the interrupt enable in bit 7 and the rate select in bits [1:0], with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe; the side effects of a read occur at the clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 count high, 1 count low, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high; 0 otherwise |
| count | output | 16 | Live counter value |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The properties assume that the bus issues at most one strobe per cycle. They also assume that `addr` and `wr_data` are stable from the falling edge to the rising edge that consumes them. The stimulus drives every access at a falling edge and releases it just after the following rising edge, so no read and write ever overlap. The coherent-read property also assumes that a low-byte read directly after a high-byte read belongs to the same pair. The bench orders its random operations so that each high-byte read is followed by its own low-byte read before another pair starts.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int PRE_W = 4;

    typedef enum logic [1:0] {
        REG_CNT_HI = 2'd0,
        REG_CNT_LO = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } frc_reg_e;

    typedef enum logic [1:0] {
        DIV_1  = 2'd0,
        DIV_4  = 2'd1,
        DIV_8  = 2'd2,
        DIV_16 = 2'd3
    } frc_div_e;

    // Low prescaler bits that must all be ones for a tick.
    function automatic logic [PRE_W-1:0] div_mask(frc_div_e d);
        logic [PRE_W-1:0] m;
        unique case (d)
            DIV_1:   m = 4'h0;
            DIV_4:   m = 4'h3;
            DIV_8:   m = 4'h7;
            DIV_16:  m = 4'hF;
            default: m = 4'h0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler
    import frc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  frc_div_e sel,
    output logic     tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    always_comb begin
        mask = div_mask(sel);
        tick = ((phase_q & mask) == mask);
    end

endmodule

// File: rtl/frc_rate_lock.sv
module frc_rate_lock
    import frc_pkg::*;
#(
    parameter int WIN_CYCLES = 64
)(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  frc_div_e wr_sel,
    output frc_div_e sel,
    output logic     shut
);

    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

    typedef enum logic {LK_OPEN, LK_SHUT} lock_state_e;

    lock_state_e      state_q, state_d;
    logic [WIN_W-1:0] win_q;
    logic             load_sel;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // Next state: first_write / window_expired
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (ctrl_wr || (win_q == WIN_LAST)) state_d = LK_SHUT;
            LK_SHUT: state_d = LK_SHUT;
            default: state_d = LK_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        load_sel = (state_q == LK_OPEN) && ctrl_wr;
        shut     = (state_q == LK_SHUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            sel   <= DIV_1;
        end else begin
            if (state_q == LK_OPEN) win_q <= win_q + 1'b1;
            if (load_sel)           sel   <= wr_sel;
        end
    end

endmodule

// File: rtl/frc_read_hold.sv
module frc_read_hold #(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hi_rd,
    input  logic         lo_rd,
    input  logic [W-1:0] live_lo,
    output logic [W-1:0] lo_out
);

    typedef enum logic {RH_LIVE, RH_HELD} hold_state_e;

    hold_state_e  state_q, state_d;
    logic [W-1:0] hold_q;

    // State register and holding byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RH_LIVE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hi_rd) hold_q <= live_lo;
        end
    end

    // Next state: capture / recapture / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RH_LIVE: if (hi_rd) state_d = RH_HELD;
            RH_HELD: begin
                if (hi_rd)      state_d = RH_HELD;
                else if (lo_rd) state_d = RH_LIVE;
            end
            default: state_d = RH_LIVE;
        endcase
    end

    // Outputs
    always_comb begin
        lo_out = (state_q == RH_HELD) ? hold_q : live_lo;
    end

endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_pkg::*;
#(
    parameter int BUS_W      = 8,
    parameter int WIN_CYCLES = 64
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [BUS_W-1:0]   wr_data,
    output logic [BUS_W-1:0]   rd_data,
    output logic [2*BUS_W-1:0] count,
    output logic               ovf_irq
);

    localparam int CNT_W = 2 * BUS_W;
    localparam int TOP_B = BUS_W - 1;

    frc_reg_e   reg_sel;
    frc_div_e   sel;
    logic       tick, wrap, lock_shut;
    logic       ctrl_wr, stat_wr, hi_rd, lo_rd;
    logic       ovf_en, ovf_flag;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] lo_byte;
    logic       unused_wr_bits;

    assign reg_sel        = frc_reg_e'(addr);
    assign ctrl_wr        = wr_en && (reg_sel == REG_CTRL);
    assign stat_wr        = wr_en && (reg_sel == REG_STAT);
    assign hi_rd          = rd_en && (reg_sel == REG_CNT_HI);
    assign lo_rd          = rd_en && (reg_sel == REG_CNT_LO);
    assign unused_wr_bits = ^wr_data[TOP_B-1:2];

    frc_rate_lock #(.WIN_CYCLES(WIN_CYCLES)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wr_sel  (frc_div_e'(wr_data[1:0])),
        .sel     (sel),
        .shut    (lock_shut)
    );

    frc_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .tick  (tick)
    );

    frc_read_hold #(.W(BUS_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_rd   (hi_rd),
        .lo_rd   (lo_rd),
        .live_lo (cnt_q[BUS_W-1:0]),
        .lo_out  (lo_byte)
    );

    assign wrap = tick && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ovf_en   <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (tick)    cnt_q  <= cnt_q + 1'b1;
            if (ctrl_wr) ovf_en <= wr_data[TOP_B];
            if (wrap)                          ovf_flag <= 1'b1;
            else if (stat_wr && wr_data[TOP_B]) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_sel)
                REG_CNT_HI: rd_data = cnt_q[CNT_W-1:BUS_W];
                REG_CNT_LO: rd_data = lo_byte;
                REG_CTRL: begin
                    rd_data[TOP_B] = ovf_en;
                    rd_data[1:0]   = sel;
                end
                REG_STAT:   rd_data[TOP_B] = ovf_flag;
                default:    rd_data = '0;
            endcase
        end
    end

    assign count   = cnt_q;
    assign ovf_irq = ovf_flag && ovf_en;

endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
    parameter int BUS_W = 8
)(
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [BUS_W-1:0]   wr_data,
    input logic [BUS_W-1:0]   rd_data,
    input logic [2*BUS_W-1:0] count,
    input logic               ovf_irq,
    input logic               tick,
    input logic               ovf_flag,
    input logic [1:0]         sel,
    input logic               lock_shut
);

    localparam int CNT_W = 2 * BUS_W;

    // R1: the first sampled edge after release still sees the reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0 && !ovf_irq));

    // R5: the count only ever moves by one step, so it cannot be loaded
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1)));

    // R4: a shut lock keeps the rate select frozen
    p_sel_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_shut |=> $stable(sel));

    // R8: a wrap leaves the overflow flag set
    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && $past(count) == {CNT_W{1'b1}}) |-> ovf_flag);

    // R10: a clear with no wrap in the same cycle drops the flag
    p_clear_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wr_data[BUS_W-1] && !(tick && count == {CNT_W{1'b1}}))
        |=> !ovf_flag);

    // R6: a low read right after a high read returns the byte captured then
    p_coherent_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0) |=>
        (!(rd_en && addr == 2'd1) || rd_data == $past(count[BUS_W-1:0])));

    // R9: no request without a pending flag
    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_flag);

endmodule

bind frc_timer frc_timer_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .count     (count),
    .ovf_irq   (ovf_irq),
    .tick      (tick),
    .ovf_flag  (ovf_flag),
    .sel       (sel),
    .lock_shut (lock_shut)
);

// File: tb/frc_timer_tb.sv
`timescale 1ns/1ps
module frc_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic [15:0] count;
    logic        ovf_irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] snap;

    always #2.5 clk = ~clk;

    frc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .count(count), .ovf_irq(ovf_irq)
    );

    function automatic int exp_div(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [7:0] exp_ctrl(input logic en, input logic [1:0] s);
        return {en, 5'b0, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        d = rd_data; snap = count;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rate_check(input string req, input logic [1:0] s);
        logic [15:0] c0;
        @(negedge clk); c0 = count;
        repeat (64) @(posedge clk);
        @(negedge clk);
        chk(req, 32'(count - c0), 32'(64 / exp_div(s)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  d, hi, lo;
        logic [15:0] c0, hsnap;
        logic        en;
        void'($urandom(32'd1234));

        // R1 reset state
        do_reset();
        chk("R1 count", 32'(count), 32'h0);
        chk("R1 irq", 32'(ovf_irq), 32'h0);
        rd(2'd2, d); chk("R1 ctrl", 32'(d), 32'h0);
        rd(2'd3, d); chk("R1 stat", 32'(d), 32'h0);

        // R2/R3/R4/R11 each rate, second write rejected but enable taken
        for (int s = 0; s < 4; s++) begin
            do_reset();
            wr(2'd2, 8'(s));
            rd(2'd2, d); chk("R3 R11 ctrl after first write", 32'(d), 32'(exp_ctrl(1'b0, 2'(s))));
            rate_check("R2 rate", 2'(s));
            wr(2'd2, 8'h80 | 8'(s ^ 3));
            rd(2'd2, d); chk("R4 select locked, enable writable", 32'(d), 32'(exp_ctrl(1'b1, 2'(s))));
            rate_check("R4 rate unchanged", 2'(s));
        end

        // R3 window boundary: edge 64 accepted
        do_reset();
        repeat (63) @(posedge clk);
        wr(2'd2, 8'h02);
        rd(2'd2, d); chk("R3 write at last window edge", 32'(d), 32'h02);
        // R4 edge 65 rejected
        do_reset();
        repeat (64) @(posedge clk);
        wr(2'd2, 8'h02);
        rd(2'd2, d); chk("R4 write after window", 32'(d), 32'h00);
        rate_check("R4 rate stays divide-by-1", 2'd0);

        // R5 writes to count addresses at divide-by-1
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); c0 = count;
            wr(2'(i & 1), 8'($urandom));
            @(negedge clk);
            chk("R5 count not writable", 32'(count - c0), 32'd2);
        end

        // R6/R7 directed: capture, then live low read
        rd(2'd0, hi); hsnap = snap;
        repeat (5) @(posedge clk);
        rd(2'd1, lo);
        chk("R6 high byte", 32'(hi), 32'(hsnap[15:8]));
        chk("R6 held low byte", 32'(lo), 32'(hsnap[7:0]));
        rd(2'd1, lo);
        chk("R7 live low byte", 32'(lo), 32'(snap[7:0]));

        // Random mix at divide-by-4
        do_reset();
        wr(2'd2, 8'h01);
        en = 1'b0;
        for (int i = 0; i < 150; i++) begin
            case ($urandom % 4)
                0: begin
                    rd(2'd0, hi); hsnap = snap;
                    repeat ($urandom % 5) @(posedge clk);
                    rd(2'd1, lo);
                    chk("R6 random pair", 32'({hi, lo}), 32'(hsnap));
                end
                1: begin
                    rd(2'd1, lo);
                    chk("R7 random live low", 32'(lo), 32'(snap[7:0]));
                end
                2: begin
                    d = 8'($urandom);
                    en = d[7];
                    wr(2'd2, d);
                    rd(2'd2, d);
                    chk("R4 R11 random ctrl", 32'(d), 32'(exp_ctrl(en, 2'd1)));
                end
                default: begin
                    @(negedge clk); c0 = count;
                    wr(2'($urandom % 2), 8'($urandom));
                    @(negedge clk);
                    chk("R5 random write ignored", 32'((count - c0) <= 16'd1), 32'd1);
                end
            endcase
        end

        // R8/R9/R10 overflow path at divide-by-1 with enable set
        do_reset();
        wr(2'd2, 8'h80);
        @(negedge clk);
        while (count != 16'hFFFF) @(negedge clk);
        rd_en = 1'b1; addr = 2'd3;
        #1;
        chk("R8 flag clear before wrap", 32'(rd_data), 32'h00);
        chk("R9 no irq before wrap", 32'(ovf_irq), 32'h0);
        @(negedge clk);
        chk("R8 count wrapped", 32'(count), 32'h0);
        chk("R8 flag set on wrap", 32'(rd_data), 32'h80);
        chk("R9 irq raised", 32'(ovf_irq), 32'h1);
        rd_en = 1'b0;
        wr(2'd3, 8'h7F);
        rd(2'd3, d); chk("R10 write 0 keeps flag", 32'(d), 32'h80);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R9 irq masked", 32'(ovf_irq), 32'h0);
        wr(2'd3, 8'h80);
        rd(2'd3, d); chk("R10 write 1 clears flag", 32'(d), 32'h00);
        wr(2'd2, 8'h80);
        @(negedge clk);
        chk("R9 no irq without flag", 32'(ovf_irq), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule